// File: doc/BRIEF.md
# Adaptive Rice Block Encoder

This block entropy-codes a stream of mapped, non-negative prediction residuals. Samples arrive one per cycle with a valid strobe. Every 16 consecutive accepted samples form a block that is coded on its own. While a block is being written into a small buffer memory, the encoder keeps a running total of the coded length for every split parameter in parallel. Once the last sample arrives, it picks the cheapest coding option and then writes a 3-bit option identifier followed by the variable-length codes. A block whose coded samples are all zero collapses to its identifier alone.

To keep channel errors from spreading, the first sample of every reference block is sent uncompressed, directly after the identifier. Reference blocks recur at a programmable interval of blocks, and every segment starts with one. A load strobe with a value input changes the interval at run time. The coded bit stream is packed MSB-first into bytes, each marked by a one-cycle enable. At the end of each segment of blocks the last partial byte is filled with zeros. The reference flag and the block-end marker are generated inside the block by its own counters.

Top module: `rice_block_enc`

## Requirements
- R1: A sample on `in_data` is taken only in a cycle where `in_valid` and `in_ready` are both high. A block is J=16 consecutive accepted samples. `in_valid` while `in_ready` is low, or idle cycles in the middle of a block, add nothing to the stream.
- R2: `in_ready` falls in the cycle after the 16th sample of a block is accepted. It stays low until the block's code and any segment padding have been emitted, so no byte is output while `in_ready` is high.
- R3: Option choice. If every coded sample is zero, the identifier is 000 (zero block). Otherwise the split parameter k in 0..5 with the least total length sum((d>>k)+1+k) is chosen, with ties going to the smaller k, and the identifier is k+1. Identifier 111 (uncompressed, 8 bits per sample) is chosen only if 8 times the number of coded samples is strictly less than that best length.
- R4: The code for sample d with parameter k is (d>>k) zero bits, then a one bit, then the k low bits of d, MSB first. An uncompressed sample is its 8 bits, MSB first.
- R5: Block layout, in order: the 3-bit identifier MSB first; in a reference block, sample 0 as 8 raw bits; then the codes of the remaining samples in arrival order. A zero block carries nothing after the identifier and the reference sample. In a reference block only samples 1..15 are coded and counted for selection.
- R6: A block is a reference block when the block counter within the interval is 0. The counter advances by one per block and wraps to 0 when it reaches the interval. The first block after reset and the first block of every segment are reference blocks.
- R7: A pulse on `ld_interval` loads the interval from `interval_val`. A value of 0 acts as 1, which makes every block a reference block. The interval after reset is REF_DEF (32).
- R8: A segment is SEG_BLOCKS (64) blocks. After the last block of a segment, zero bits are added until the stream reaches a byte boundary. Between blocks inside a segment, bits continue with no padding.
- R9: Bytes are packed MSB-first: the first bit of the stream lands in bit 7 of the first byte. `out_valid` is high for exactly one cycle per byte and is never high in two consecutive cycles.
- R10: After reset, `out_valid` is low, `in_ready` is high, and the block and segment counters start at a segment boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Mapped residual sample |
| in_valid | input | 1 | Sample present on in_data |
| in_ready | output | 1 | Encoder can take a sample |
| ld_interval | input | 1 | Load strobe for the reference interval |
| interval_val | input | 8 | New reference interval in blocks |
| out_byte | output | 8 | Packed output byte |
| out_valid | output | 1 | out_byte holds a new byte this cycle |

## Verification
The hardest situation to reach is a reference interval that changes in the middle of a segment, including the value 0. Here the position of the raw reference sample, the sample count used for option selection and the end-of-segment padding all shift together. It only shows up after several blocks whose bit lengths leave the stream at arbitrary alignments. The stimulus walks a table of block shapes chosen so that each option is selected (zero block, small and large split parameters, uncompressed). It then reloads the interval to 3 and to 0 between blocks and keeps sending until segments close, so every byte is compared with a model of the stream built from the requirements. Idle gaps inside a block and samples offered while the encoder is busy are mixed in to show that neither leaves any trace in the output bytes.

// File: rtl/rice_pkg.sv
package rice_pkg;
  typedef enum logic [2:0] {
    ST_ACC,
    ST_SEL,
    ST_BITS,
    ST_FETCH,
    ST_LOAD,
    ST_PAD
  } enc_state_t;

  localparam int         ID_W    = 3;
  localparam logic [2:0] ID_ZERO = 3'b000;
  localparam logic [2:0] ID_RAW  = 3'b111;
endpackage

// File: rtl/rice_len_acc.sv
module rice_len_acc #(
  parameter int W  = 8,
  parameter int NK = 6,
  parameter int LW = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic [W-1:0]           d,
  output logic [NK-1:0][LW-1:0]  lens,
  output logic                   all_zero
);
  // one running length per split parameter, all updated in the same cycle
  for (genvar k = 0; k < NK; k++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst || clr)
        lens[k] <= '0;
      else if (en)
        lens[k] <= lens[k] + LW'(d >> k) + LW'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      all_zero <= 1'b1;
    else if (en)
      all_zero <= all_zero & (d == '0);
  end
endmodule

// File: rtl/rice_select.sv
module rice_select import rice_pkg::*; #(
  parameter int NK = 6,
  parameter int LW = 14
) (
  input  logic [NK-1:0][LW-1:0] lens,
  input  logic                  all_zero,
  input  logic [LW-1:0]         raw_len,
  output logic [ID_W-1:0]       id
);
  logic [LW-1:0] best;
  int            best_k;

  always_comb begin
    best   = lens[0];
    best_k = 0;
    for (int k = 1; k < NK; k++) begin
      if (lens[k] < best) begin
        best   = lens[k];
        best_k = k;
      end
    end
    if (all_zero)
      id = ID_ZERO;
    else if (raw_len < best)
      id = ID_RAW;
    else
      id = ID_W'(best_k + 1);
  end
endmodule

// File: rtl/rice_bit_packer.sv
module rice_bit_packer (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_val,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       aligned
);
  logic [6:0] sh;
  logic [2:0] cnt;

  assign aligned = (cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_en) begin
        if (cnt == 3'd7) begin
          byte_o  <= {sh, bit_val};
          valid_o <= 1'b1;
          cnt     <= '0;
        end else begin
          sh  <= {sh[5:0], bit_val};
          cnt <= cnt + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rice_block_enc.sv
module rice_block_enc import rice_pkg::*; #(
  parameter int W          = 8,
  parameter int J          = 16,
  parameter int SEG_BLOCKS = 64,
  parameter int REF_DEF    = 32,
  parameter int IW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          ld_interval,
  input  logic [IW-1:0] interval_val,
  output logic [7:0]    out_byte,
  output logic          out_valid
);
  localparam int JW  = $clog2(J);
  localparam int NK  = W - 2;
  localparam int LW  = $clog2(J * ((1 << W) + W)) + 1;
  localparam int NLW = $clog2(W + 1);
  localparam int SW  = (SEG_BLOCKS > 1) ? $clog2(SEG_BLOCKS) : 1;

  enc_state_t     state;
  logic [W-1:0]   mem [J];
  logic [W-1:0]   rd_data;
  logic [JW-1:0]  wr_idx, idx;
  logic [ID_W-1:0] opt, sel_id, kk;
  logic [W-1:0]   cur, zcnt;
  logic [NLW-1:0] nlow, nsel;
  logic           need_one, is_id;
  logic [IW-1:0]  ref_cnt, ref_int;
  logic [SW-1:0]  seg_cnt;

  logic accept, blk_ref, seg_last, aligned, bit_en, bit_val, item_done, go_pad, raw_item, pad_busy;
  logic [JW:0]    next_i;
  logic [LW-1:0]  raw_len;
  logic [NK-1:0][LW-1:0] lens;
  logic           all_zero;

  assign in_ready = (state == ST_ACC);
  assign accept   = in_valid && in_ready;
  assign blk_ref  = (ref_cnt == '0);
  assign seg_last = (seg_cnt == SW'(SEG_BLOCKS - 1));
  assign raw_len  = blk_ref ? LW'(W * (J - 1)) : LW'(W * J);
  assign kk       = opt - 3'd1;
  assign nsel     = nlow - 1'b1;
  assign next_i   = is_id ? '0 : ({1'b0, idx} + 1'b1);
  assign go_pad   = (next_i == (JW+1)'(J)) || ((opt == ID_ZERO) && !(blk_ref && next_i == '0));
  assign raw_item = (blk_ref && idx == '0) || (opt == ID_RAW);
  assign pad_busy = seg_last && !aligned;

  // block buffer: written while accepting, read one item at a time while emitting
  always_ff @(posedge clk) begin
    if (accept) mem[wr_idx] <= in_data;
    rd_data <= mem[idx];
  end

  rice_len_acc #(.W(W), .NK(NK), .LW(LW)) u_len (
    .clk(clk), .rst(rst), .clr(state == ST_SEL),
    .en(accept && !(blk_ref && wr_idx == '0)),
    .d(in_data), .lens(lens), .all_zero(all_zero)
  );

  rice_select #(.NK(NK), .LW(LW)) u_sel (
    .lens(lens), .all_zero(all_zero), .raw_len(raw_len), .id(sel_id)
  );

  // bit source: zeros of the unary part, the terminating one, then low bits
  always_comb begin
    bit_en    = 1'b0;
    bit_val   = 1'b0;
    item_done = 1'b0;
    if (state == ST_BITS) begin
      if (zcnt != '0)
        bit_en = 1'b1;
      else if (need_one) begin
        bit_en  = 1'b1;
        bit_val = 1'b1;
      end else if (nlow != '0) begin
        bit_en  = 1'b1;
        bit_val = cur[nsel];
      end else
        item_done = 1'b1;
    end else if (state == ST_PAD) begin
      bit_en = pad_busy;
    end
  end

  rice_bit_packer u_pack (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_val(bit_val),
    .byte_o(out_byte), .valid_o(out_valid), .aligned(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ACC;
      wr_idx   <= '0;
      idx      <= '0;
      opt      <= '0;
      cur      <= '0;
      zcnt     <= '0;
      nlow     <= '0;
      need_one <= 1'b0;
      is_id    <= 1'b0;
      ref_cnt  <= '0;
      seg_cnt  <= '0;
      ref_int  <= IW'(REF_DEF);
    end else begin
      if (ld_interval)
        ref_int <= (interval_val == '0) ? IW'(1) : interval_val;
      case (state)
        ST_ACC: if (accept) begin
          if (wr_idx == JW'(J - 1)) begin
            wr_idx <= '0;
            state  <= ST_SEL;
          end else
            wr_idx <= wr_idx + 1'b1;
        end
        ST_SEL: begin
          opt      <= sel_id;
          cur      <= W'(sel_id);
          nlow     <= NLW'(ID_W);
          zcnt     <= '0;
          need_one <= 1'b0;
          is_id    <= 1'b1;
          state    <= ST_BITS;
        end
        ST_BITS: begin
          if (zcnt != '0)
            zcnt <= zcnt - 1'b1;
          else if (need_one)
            need_one <= 1'b0;
          else if (nlow != '0)
            nlow <= nlow - 1'b1;
          else if (go_pad)
            state <= ST_PAD;
          else begin
            idx   <= next_i[JW-1:0];
            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          cur   <= rd_data;
          is_id <= 1'b0;
          if (raw_item) begin
            zcnt     <= '0;
            need_one <= 1'b0;
            nlow     <= NLW'(W);
          end else begin
            zcnt     <= rd_data >> kk;
            need_one <= 1'b1;
            nlow     <= NLW'(kk);
          end
          state <= ST_BITS;
        end
        ST_PAD: if (!pad_busy) begin
          if (seg_last) begin
            seg_cnt <= '0;
            ref_cnt <= '0;
          end else begin
            seg_cnt <= seg_cnt + 1'b1;
            ref_cnt <= (({1'b0, ref_cnt} + 1'b1) >= {1'b0, ref_int}) ? '0 : ref_cnt + 1'b1;
          end
          state <= ST_ACC;
        end
        default: state <= ST_ACC;
      endcase
    end
  end
endmodule

// File: rtl/rice_block_enc_chk.sv
module rice_block_enc_chk #(
  parameter int J  = 16,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          ld_interval,
  input logic [IW-1:0] interval_val,
  input logic [IW-1:0] ref_int
);
  localparam int CW = $clog2(J) + 1;
  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      acc_cnt <= '0;
    else if (in_valid && in_ready)
      acc_cnt <= (acc_cnt == CW'(J - 1)) ? '0 : acc_cnt + 1'b1;
  end

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && acc_cnt == CW'(J - 1)) |=> !in_ready);

  a_r2_no_byte_while_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r7_interval_load: assert property (@(posedge clk) disable iff (rst)
    ld_interval |=> (ref_int == (($past(interval_val) == '0) ? IW'(1) : $past(interval_val))));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));
endmodule

bind rice_block_enc rice_block_enc_chk #(.J(J), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .ld_interval(ld_interval),
  .interval_val(interval_val), .ref_int(ref_int)
);

// File: tb/sim_rice_block_enc.sv
module sim_rice_block_enc;
  localparam int J   = 16;
  localparam int SEG = 5;
  localparam int NT  = 12;
  localparam int TBL [NT] = '{0, 1, 2, 3, 4, 5, 6, 7, 2, 1, 6, 3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       ld_interval = 1'b0;
  logic [7:0] interval_val = '0;
  logic [7:0] out_byte;
  logic       out_valid;

  always #10 clk = ~clk;

  rice_block_enc #(.W(8), .J(J), .SEG_BLOCKS(SEG), .REF_DEF(2), .IW(8)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .ld_interval(ld_interval), .interval_val(interval_val),
    .out_byte(out_byte), .out_valid(out_valid)
  );

  int n_chk = 0, n_fail = 0;
  int rc = 0, sc = 0, ri = 2;
  int n_bytes = 0;
  logic [7:0] first_byte = '0;
  bit finished = 0;
  bit bitq [$];
  logic [7:0] expq [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int kind, input int i);
    case (kind)
      0: return (i == 0) ? 8'hA5 : 8'h00;
      1: return 8'(i % 3);
      2: return 8'(20 + i);
      3: return 8'((i * 73 + 11) % 256);
      4: return (i % 2 == 1) ? 8'hFF : 8'h00;
      5: return 8'd7;
      6: return 8'h00;
      default: return 8'(i * 16);
    endcase
  endfunction

  task automatic push_bits(input int v, input int n);
    for (int b = n - 1; b >= 0; b--) bitq.push_back(v[b]);
  endtask

  // stream model built from R3, R4, R5, R8
  task automatic model_block(input int kind, input bit isref, input bit seglast);
    int st, best, bk, id, n;
    int lens [6];
    bit az;
    st = isref ? 1 : 0;
    n  = J - st;
    az = 1;
    for (int k = 0; k < 6; k++) lens[k] = 0;
    for (int i = st; i < J; i++) begin
      if (gen(kind, i) != 0) az = 0;
      for (int k = 0; k < 6; k++) lens[k] += (int'(gen(kind, i)) >> k) + 1 + k;
    end
    best = lens[0]; bk = 0;
    for (int k = 1; k < 6; k++) if (lens[k] < best) begin best = lens[k]; bk = k; end
    if (az) id = 0; else if (8 * n < best) id = 7; else id = bk + 1;
    push_bits(id, 3);
    if (isref) push_bits(int'(gen(kind, 0)), 8);
    if (id != 0)
      for (int i = st; i < J; i++) begin
        if (id == 7) push_bits(int'(gen(kind, i)), 8);
        else begin
          for (int z = 0; z < (int'(gen(kind, i)) >> (id - 1)); z++) bitq.push_back(1'b0);
          bitq.push_back(1'b1);
          push_bits(int'(gen(kind, i)), id - 1);
        end
      end
    if (seglast) while (bitq.size() % 8 != 0) bitq.push_back(1'b0);
    while (bitq.size() >= 8) begin
      logic [7:0] by;
      for (int b = 7; b >= 0; b--) by[b] = bitq.pop_front();
      expq.push_back(by);
    end
  endtask

  task automatic send_blk(input int kind, input bit gaps, input bit junk);
    bit isref, sl;
    isref = (rc == 0);
    sl    = (sc == SEG - 1);
    model_block(kind, isref, sl);
    for (int i = 0; i < J; i++) begin
      while (!in_ready) @(negedge clk);
      in_data  = gen(kind, i);
      in_valid = 1'b1;
      @(negedge clk);
      if (gaps && (i % 4 == 1)) begin
        in_valid = 1'b0;
        in_data  = 8'hFF;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 ready low after 16th sample", int'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1;
      in_data  = 8'h3C;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    if (sl) begin sc = 0; rc = 0; end
    else begin
      sc++;
      rc = (rc + 1 >= ri) ? 0 : rc + 1;
    end
  endtask

  task automatic load_interval(input int v);
    while (!in_ready) @(negedge clk);
    ld_interval  = 1'b1;
    interval_val = 8'(v);
    @(negedge clk);
    ld_interval = 1'b0;
    ri = (v == 0) ? 1 : v;
  endtask

  // byte monitor: R4 R5 R6 R7 R8 R9 covered by the byte-exact comparison
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (n_bytes == 0) first_byte = out_byte;
      n_bytes++;
      if (expq.size() == 0)
        chk(1'b0, "R1 R9 unexpected extra byte", int'(out_byte), 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(out_byte == e, "R3 R4 R5 R6 R7 R8 R9 stream byte", int'(out_byte), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 no byte after reset", int'(out_valid), 0);

    for (int t = 0; t < NT; t++) send_blk(TBL[t], 1'b0, 1'b0);
    // first block is a reference zero block: 000 then A5 -> 0001_0100
    chk(first_byte == 8'h14, "R3 R5 zero block with reference", int'(first_byte), 8'h14);

    send_blk(2, 1'b1, 1'b0);   // R1 idle gaps inside a block
    send_blk(5, 1'b0, 1'b1);   // R1 R2 samples offered while busy

    load_interval(3);          // R7
    for (int t = 0; t < 4; t++) send_blk(TBL[(t + 3) % NT], 1'b0, 1'b0);
    load_interval(0);          // R7 zero acts as one
    for (int t = 0; t < 3; t++) send_blk(TBL[(t + 5) % NT], 1'b0, 1'b0);
    while (sc != 0) send_blk(1, 1'b0, 1'b0);

    repeat (800) @(negedge clk);
    chk(expq.size() == 0, "R8 all expected bytes delivered", expq.size(), 0);
    chk(bitq.size() == 0, "R8 segment ends on byte boundary", bitq.size(), 0);
    chk(in_ready == 1'b1, "R2 ready after emission", int'(in_ready), 1);
    chk(n_bytes > 20, "R9 bytes produced", n_bytes, 21);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule